// File: doc/BRIEF.md
# Banked Working-Register RAM with Upward Stack

This block is the internal data memory of a small 8-bit controller core. It holds the on-chip RAM (128 bytes by default) and an 8-bit stack pointer. The lowest 32 bytes hold four banks of eight working registers. A 2-bit bank select picks which bank the register numbers 0 to 7 reach. Indirect accesses take their address from working register 0 or 1 of the current bank. Push and pop move the stack pointer around the memory access, so the stack grows toward higher addresses.

The core issues one request per cycle on a 4-bit operation code. Reads return data one cycle later, marked by `rvalid`. A move between two direct addresses copies a byte without any other path. It takes two cycles, and `busy` marks the second one. Any effective address outside the RAM raises `range_err` and writes nothing.

Top module: `bank_ram_stack`

## Requirements
- R1: During and after reset, `sp` is 0x07 and `rvalid`, `range_err` and `busy` are 0.
- R2: Operation 1 (register read) and operation 2 (register write) reach RAM address `rs`*8 + `reg_idx`, where `rs`=0..3 selects the bank at 0x00, 0x08, 0x10 or 0x18.
- R3: Operation 3 (direct read) and operation 4 (direct write) reach RAM address `addr`. A read returns its byte on `rdata` with `rvalid`=1 in the cycle after the request, and `rvalid` is 0 again one cycle later unless another read follows.
- R4: Operation 5 (indirect read) and operation 6 (indirect write) use as address the byte held in working register 0 of the current bank when `reg_idx[0]`=0, or in working register 1 when `reg_idx[0]`=1.
- R5: Operation 7 (push) first adds 1 to `sp` and then writes `wdata` to the new `sp`. After reset the first push lands at 0x08.
- R6: Operation 8 (pop) returns the byte at the current `sp` on `rdata` with `rvalid` in the next cycle, and `sp` is then one lower. Pops return pushed data in reverse order.
- R7: An effective address at or above 0x80 from a direct, indirect or stack access sets `range_err` to 1 for one cycle and writes no memory location. A read of such an address returns 0. Push and pop still change `sp`.
- R8: Operation 9 (move) copies the byte at `addr` to `dst_addr`. `busy` is 1 in the cycle after the request, and any request made during that cycle is ignored. If either address is out of range, `range_err` is set instead and `busy` stays 0.
- R9: Operation 0 and operations 10 to 15 change no memory, do not change `sp`, and leave `rvalid` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op | input | 4 | Operation code, 0 is idle |
| rs | input | 2 | Bank select, high bit first |
| reg_idx | input | 3 | Working register number (bit 0 picks the indirect pointer) |
| addr | input | 8 | Direct address, or move source |
| dst_addr | input | 8 | Move destination |
| wdata | input | 8 | Write or push data |
| rdata | output | 8 | Read or pop data |
| rvalid | output | 1 | `rdata` holds the result of the previous read |
| range_err | output | 1 | Previous request used an address outside the RAM |
| busy | output | 1 | Second cycle of a move; requests are ignored |
| sp | output | 8 | Stack pointer |

## Verification
The bench builds the block with its default parameters: 128 bytes of RAM, an 8-bit address and a stack pointer that starts at 0x07. With these values an address with bit 7 set aliases a valid RAM index once bit 7 is dropped. The bench therefore plants known bytes at those alias locations to show that out-of-range writes land nowhere. With a 128-byte RAM, a run of 121 pushes from reset carries the stack pointer past the top of the RAM. This exercises the stack overflow boundary and the pop back across it.

// File: rtl/bank_ram_stack.sv
module bank_ram_stack #(
  parameter int DW = 8,
  parameter int DEPTH = 128,
  parameter int AW = 8,
  parameter logic [AW-1:0] SP_INIT = 8'h07
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    op,
  input  logic [1:0]    rs,
  input  logic [2:0]    reg_idx,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] dst_addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rvalid,
  output logic          range_err,
  output logic          busy,
  output logic [AW-1:0] sp
);
  localparam int IW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] hold;
  logic [IW-1:0] mv_dst;

  logic [AW-1:0] ea;
  logic          rd, wr, mv, uses_addr;

  wire [AW-1:0] reg_addr = AW'({rs, reg_idx});
  wire [AW-1:0] ptr      = AW'(mem[IW'({rs, 2'b00, reg_idx[0]})]);
  wire [AW-1:0] sp_up    = sp + AW'(1);
  wire          ea_ok    = ~|ea[AW-1:IW];
  wire          dst_ok   = ~|dst_addr[AW-1:IW];
  wire          go       = !busy;
  wire          bad      = go && uses_addr && (!ea_ok || (mv && !dst_ok));

  always_comb begin
    ea = addr;
    rd = 1'b0;
    wr = 1'b0;
    mv = 1'b0;
    uses_addr = 1'b1;
    case (op)
      4'd1: begin ea = reg_addr; rd = 1'b1; end
      4'd2: begin ea = reg_addr; wr = 1'b1; end
      4'd3: rd = 1'b1;
      4'd4: wr = 1'b1;
      4'd5: begin ea = ptr; rd = 1'b1; end
      4'd6: begin ea = ptr; wr = 1'b1; end
      4'd7: begin ea = sp_up; wr = 1'b1; end
      4'd8: begin ea = sp; rd = 1'b1; end
      4'd9: mv = 1'b1;
      default: uses_addr = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (busy)
      mem[mv_dst] <= hold;
    else if (wr && ea_ok)
      mem[ea[IW-1:0]] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp        <= SP_INIT;
      rdata     <= '0;
      rvalid    <= 1'b0;
      range_err <= 1'b0;
      busy      <= 1'b0;
      hold      <= '0;
      mv_dst    <= '0;
    end else if (busy) begin
      busy      <= 1'b0;
      rvalid    <= 1'b0;
      range_err <= 1'b0;
    end else begin
      rvalid    <= rd;
      rdata     <= (rd && ea_ok) ? mem[ea[IW-1:0]] : '0;
      range_err <= bad;
      if (op == 4'd7) sp <= sp_up;
      if (op == 4'd8) sp <= sp - AW'(1);
      if (mv && !bad) begin
        hold   <= mem[ea[IW-1:0]];
        mv_dst <= dst_addr[IW-1:0];
        busy   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bank_ram_stack_chk.sv
module bank_ram_stack_chk #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    op,
  input logic          busy,
  input logic          rvalid,
  input logic          range_err,
  input logic [DW-1:0] rdata,
  input logic [AW-1:0] sp
);
  // R5
  push_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd7 && !busy) |=> sp == $past(sp) + AW'(1));

  // R6
  pop_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd8 && !busy) |=> sp == $past(sp) - AW'(1));

  // R8
  move_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy && !rvalid && $stable(sp));

  // R7
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (range_err && rvalid) |-> rdata == '0);

  // R9
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((op == 4'd0 || op > 4'd9) && !busy) |=> $stable(sp) && !rvalid && !busy);

  // R3
  read_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((op == 4'd1 || op == 4'd3 || op == 4'd5 || op == 4'd8) && !busy) |=> rvalid);
endmodule

bind bank_ram_stack bank_ram_stack_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op(op), .busy(busy), .rvalid(rvalid),
  .range_err(range_err), .rdata(rdata), .sp(sp)
);

// File: tb/sim_bank_ram_stack.sv
module sim_bank_ram_stack;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] op = '0;
  logic [1:0] rs = '0;
  logic [2:0] reg_idx = '0;
  logic [7:0] addr = '0, dst_addr = '0, wdata = '0;
  logic [7:0] rdata, sp;
  logic rvalid, range_err, busy;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  bank_ram_stack u0 (.clk(clk), .rst_n(rst_n), .op(op), .rs(rs), .reg_idx(reg_idx),
    .addr(addr), .dst_addr(dst_addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
    .range_err(range_err), .busy(busy), .sp(sp));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] o, input logic [1:0] b, input logic [2:0] r,
                       input logic [7:0] a, input logic [7:0] d, input logic [7:0] w);
    op = o; rs = b; reg_idx = r; addr = a; dst_addr = d; wdata = w;
    @(negedge clk);
    op = 4'd0;
  endtask

  task automatic wr_dir(input logic [7:0] a, input logic [7:0] w);
    issue(4'd4, 2'd0, 3'd0, a, 8'h00, w);
  endtask

  task automatic rd_dir(input logic [7:0] a, output logic [7:0] v);
    issue(4'd3, 2'd0, 3'd0, a, 8'h00, 8'h00);
    v = rdata;
  endtask

  task automatic t_reset();
    chk(sp == 8'h07, "R1 sp", sp, 8'h07);
    chk(!rvalid && !range_err && !busy, "R1 flags", {rvalid, range_err, busy}, 0);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    for (int b = 0; b < 4; b++) issue(4'd2, 2'(b), 3'd3, 8'h00, 8'h00, 8'(8'h30 + b));
    for (int b = 0; b < 4; b++) begin
      rd_dir(8'(b * 8 + 3), v);
      chk(v == 8'(8'h30 + b), "R2 bank write", v, 8'h30 + b);
    end
    wr_dir(8'h16, 8'h9C);
    issue(4'd1, 2'd2, 3'd6, 8'h00, 8'h00, 8'h00);
    chk(rvalid && rdata == 8'h9C, "R2 bank read", rdata, 8'h9C);
  endtask

  task automatic t_direct();
    logic [7:0] v;
    wr_dir(8'h7F, 8'hA5);
    rd_dir(8'h7F, v);
    chk(rvalid && v == 8'hA5, "R3 direct read", v, 8'hA5);
    @(negedge clk);
    chk(!rvalid, "R3 rvalid drop", rvalid, 0);
  endtask

  task automatic t_indirect();
    logic [7:0] v;
    wr_dir(8'h08, 8'h40);
    wr_dir(8'h09, 8'h41);
    issue(4'd6, 2'd1, 3'd0, 8'h00, 8'h00, 8'h11);
    issue(4'd6, 2'd1, 3'd1, 8'h00, 8'h00, 8'h22);
    rd_dir(8'h40, v);
    chk(v == 8'h11, "R4 indirect via R0", v, 8'h11);
    rd_dir(8'h41, v);
    chk(v == 8'h22, "R4 indirect via R1", v, 8'h22);
    wr_dir(8'h00, 8'h50);
    wr_dir(8'h50, 8'h77);
    issue(4'd5, 2'd0, 3'd2, 8'h00, 8'h00, 8'h00);
    chk(rvalid && rdata == 8'h77, "R4 indirect read bank0", rdata, 8'h77);
  endtask

  task automatic t_stack();
    logic [7:0] v;
    issue(4'd7, 2'd0, 3'd0, 8'h00, 8'h00, 8'h01);
    chk(sp == 8'h08, "R5 sp after push", sp, 8'h08);
    rd_dir(8'h08, v);
    chk(v == 8'h01, "R5 first push at 0x08", v, 8'h01);
    issue(4'd7, 2'd0, 3'd0, 8'h00, 8'h00, 8'h02);
    chk(sp == 8'h09, "R5 sp second push", sp, 8'h09);
    issue(4'd8, 2'd0, 3'd0, 8'h00, 8'h00, 8'h00);
    chk(rvalid && rdata == 8'h02, "R6 pop data", rdata, 8'h02);
    chk(sp == 8'h08, "R6 sp after pop", sp, 8'h08);
    issue(4'd8, 2'd0, 3'd0, 8'h00, 8'h00, 8'h00);
    chk(rdata == 8'h01 && sp == 8'h07, "R6 LIFO order", {rdata, sp}, 16'h0107);
  endtask

  task automatic t_range();
    logic [7:0] v;
    wr_dir(8'h10, 8'h5A);
    wr_dir(8'h90, 8'hFF);
    chk(range_err, "R7 direct err", range_err, 1);
    rd_dir(8'h10, v);
    chk(v == 8'h5A, "R7 no alias write", v, 8'h5A);
    rd_dir(8'h90, v);
    chk(range_err && v == 8'h00, "R7 bad read zero", v, 0);
    wr_dir(8'h05, 8'h66);
    wr_dir(8'h18, 8'h85);
    issue(4'd6, 2'd3, 3'd0, 8'h00, 8'h00, 8'hEE);
    chk(range_err, "R7 indirect err", range_err, 1);
    rd_dir(8'h05, v);
    chk(v == 8'h66 && !range_err, "R7 indirect no write", v, 8'h66);
  endtask

  task automatic t_move();
    logic [7:0] v;
    wr_dir(8'h20, 8'hC3);
    wr_dir(8'h31, 8'h0D);
    issue(4'd9, 2'd0, 3'd0, 8'h20, 8'h30, 8'h00);
    chk(busy, "R8 busy", busy, 1);
    wr_dir(8'h31, 8'hEE);
    chk(!busy && !range_err, "R8 busy ends", busy, 0);
    rd_dir(8'h30, v);
    chk(v == 8'hC3, "R8 move copy", v, 8'hC3);
    rd_dir(8'h31, v);
    chk(v == 8'h0D, "R8 request during busy ignored", v, 8'h0D);
    issue(4'd9, 2'd0, 3'd0, 8'h20, 8'h85, 8'h00);
    chk(range_err && !busy, "R8 move bad dst", {range_err, busy}, 2);
  endtask

  task automatic t_idle();
    logic [7:0] v;
    logic [7:0] s0;
    s0 = sp;
    issue(4'd0, 2'd0, 3'd0, 8'h20, 8'h00, 8'h00);
    chk(!rvalid && sp == s0, "R9 op0", sp, s0);
    issue(4'd12, 2'd0, 3'd0, 8'h20, 8'h20, 8'h00);
    chk(!rvalid && !busy && sp == s0, "R9 op12", sp, s0);
    rd_dir(8'h20, v);
    chk(v == 8'hC3, "R9 op12 no write", v, 8'hC3);
  endtask

  task automatic t_overflow();
    logic [7:0] v;
    wr_dir(8'h00, 8'h3C);
    for (int i = 1; i <= 120; i++) issue(4'd7, 2'd0, 3'd0, 8'h00, 8'h00, 8'(i));
    chk(sp == 8'h7F && !range_err, "R5 sp at top", sp, 8'h7F);
    issue(4'd7, 2'd0, 3'd0, 8'h00, 8'h00, 8'hAA);
    chk(range_err && sp == 8'h80, "R7 push overflow", sp, 8'h80);
    rd_dir(8'h00, v);
    chk(v == 8'h3C, "R7 overflow no write", v, 8'h3C);
    issue(4'd8, 2'd0, 3'd0, 8'h00, 8'h00, 8'h00);
    chk(range_err && rdata == 8'h00 && sp == 8'h7F, "R7 pop above top", sp, 8'h7F);
    issue(4'd8, 2'd0, 3'd0, 8'h00, 8'h00, 8'h00);
    chk(rdata == 8'd120 && sp == 8'h7E, "R6 pop last push", rdata, 120);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_direct();
    t_indirect();
    t_stack();
    t_range();
    t_move();
    t_idle();
    t_overflow();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule